// File: doc/BRIEF.md
# Interrupt-Activated Transfer Engine with Descriptor Read Skip

This block moves one data element between two memory addresses each time an enabled peripheral request fires. Every request line has its own enable bit. A pending request from an enabled line starts the engine. The engine reads a pointer for that line from a vector table and fetches a six-word descriptor from where the pointer leads. It reads one element from the source address, writes it to the destination address, and stores the updated descriptor back. A pending request from a disabled line is routed to the CPU interrupt output and starts nothing.

At the end of each move the engine does one of two things. It pulses a clear to the activating line's request flag. Or it drops that line's enable bit, so the still-pending request reaches the CPU. A read-skip control bit lets the engine keep the descriptor it just wrote back. When the same line fires again in a row, the vector and descriptor reads are then left out. Writing the control bit to zero forgets the kept copy.

Top module: `dtx_top`

## Requirements
- R1: After reset, `src_en`, `src_clr`, `cpu_irq`, `busy` and `mem_req` are all zero.
- R2: A one-cycle `en_set` pulse sets the matching `src_en` bits. A pending `src_req` bit whose enable is 0 appears on the matching `cpu_irq` bit and starts no memory access.
- R3: When several enabled requests are pending, the lowest-numbered line is served first, and the others wait until the engine is idle again.
- R4: A fetched activation performs exactly 8 reads and 7 writes. The reads are the vector word at `VEC_BASE + 4*line`, six descriptor words starting at the address read from the vector, and the element at the source address. The writes are the element to the destination address and the six descriptor words back to the same place.
- R5: Descriptor words, in order, are: mode, auxiliary mode, source address, destination address, count, auxiliary count. In the mode word, bits [1:0] give the size (0 byte, 1 halfword, 2 or 3 word), bit 2 sets source increment, bit 3 sets destination increment, and bit 4 sets disable-after-move. The count is bits [15:0] of the count word. Words 1 and 5 are written back unchanged.
- R6: After a move, each address whose increment bit is set grows by the size in bytes (1, 2 or 4). The count drops by one.
- R7: If the new count is zero or mode bit 4 is set, the line's enable bit is cleared, no clear pulse is given, and the request then shows on `cpu_irq`. Otherwise exactly one one-cycle `src_clr` pulse is given for that line, and its enable bit stays set.
- R8: With the read-skip control at 1, a second consecutive activation by the same line performs only the element read (1 read, 7 writes). It uses the kept descriptor.
- R9: An activation by another line in between makes the next activation fetch again.
- R10: Writing the read-skip control to 0 discards the kept copy. The next activation fetches, even if the control is set back to 1 first.
- R11: A change to the read-skip control while `busy` is high does not apply to the move in progress. A move started with the control at 0 never arms a skip for the next one.
- R12: `busy` is high from the start of an activation to its end. While `mem_req` is high and `mem_ack` is low, the address, write flag and write data hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_req | input | NSRC | Request flags from the peripherals |
| en_set | input | NSRC | One-cycle pulse that sets enable bits |
| ctl_wr | input | 1 | Write strobe for the read-skip control |
| ctl_skip | input | 1 | Value written to the read-skip control |
| src_en | output | NSRC | Current enable bits |
| src_clr | output | NSRC | One-cycle clear for a request flag |
| cpu_irq | output | NSRC | Requests routed to the CPU |
| busy | output | 1 | Engine is serving an activation |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | AW | Byte address |
| mem_wdata | output | DW | Write data |
| mem_size | output | 2 | Element size during the data move |
| mem_ack | input | 1 | Access accepted; read data valid |
| mem_rdata | input | DW | Read data |

## Verification
The assertions watch, on every cycle, the properties that do not depend on a scenario. They check that the winner of arbitration is the lowest pending line, that the clear output is at most one-hot and goes only to a line that stays enabled, and that memory requests stay steady until acknowledged. They also check that a zero write to the skip control invalidates the kept copy on the next cycle. Only the bench's scenarios can show the other behaviours. These are the access counts that separate a fetch from a skip, the updated addresses and counts in memory, the moved data, and the choice between clear pulse and disable. The same holds for the ordering cases: a different line in between, a control write of 0 then 1, and a control write during a move.

// File: rtl/dtx_pkg.sv
package dtx_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_VEC, S_DESC, S_RD, S_WR, S_WB, S_FIN
  } dtx_state_t;

  localparam int DESC_WORDS = 6;
  localparam int D_MODE     = 0;
  localparam int D_SRC      = 2;
  localparam int D_DST      = 3;
  localparam int D_CNT      = 4;

  localparam int MB_SINC = 2;
  localparam int MB_DINC = 3;
  localparam int MB_DIS  = 4;
endpackage

// File: rtl/dtx_arb.sv
module dtx_arb #(
  parameter int N  = 8,
  parameter int IW = 3
) (
  input  logic [N-1:0]  req,
  output logic          any,
  output logic [IW-1:0] idx
);
  always_comb begin
    any = |req;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IW'(i);
    end
  end

  // R3: the chosen line is pending and no lower line is pending
  always_comb begin
    if (any) begin
      a_r3_lowest_wins: assert (req[idx] && ((req & ((N'(1) << idx) - N'(1))) == '0));
    end
  end
endmodule

// File: rtl/dtx_skip.sv
module dtx_skip #(
  parameter int IW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ctl_wr,
  input  logic          ctl_val,
  input  logic          start,
  input  logic [IW-1:0] start_src,
  input  logic          finish,
  input  logic [IW-1:0] fin_src,
  output logic          skip_go
);
  logic          ctl_q, ctl_lat, killed, last_valid;
  logic [IW-1:0] last_src;
  logic          wipe;

  assign wipe    = ctl_wr && !ctl_val;
  assign skip_go = ctl_q && last_valid && (last_src == start_src);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q      <= 1'b0;
      ctl_lat    <= 1'b0;
      killed     <= 1'b0;
      last_valid <= 1'b0;
      last_src   <= '0;
    end else begin
      if (start) begin
        ctl_lat <= ctl_q;
        killed  <= 1'b0;
      end
      if (finish) begin
        if (ctl_lat && !killed) begin
          last_valid <= 1'b1;
          last_src   <= fin_src;
        end else begin
          last_valid <= 1'b0;
        end
      end
      if (ctl_wr) ctl_q <= ctl_val;
      if (wipe) begin
        last_valid <= 1'b0;
        killed     <= 1'b1;
      end
    end
  end

  // R10: a zero write to the control forgets the kept descriptor
  a_r10_wipe_forgets: assert property (@(posedge clk) disable iff (rst)
    (ctl_wr && !ctl_val) |=> !last_valid);
endmodule

// File: rtl/dtx_step.sv
module dtx_step #(
  parameter int DW = 32,
  parameter int CW = 16
) (
  input  logic [DW-1:0] mode,
  input  logic [DW-1:0] sar,
  input  logic [DW-1:0] dar,
  input  logic [DW-1:0] cnt,
  output logic [DW-1:0] nsar,
  output logic [DW-1:0] ndar,
  output logic [DW-1:0] ncnt,
  output logic          stop
);
  import dtx_pkg::*;
  logic [DW-1:0] inc;
  logic [CW-1:0] cdec;

  always_comb begin
    unique case (mode[1:0])
      2'd0:    inc = DW'(1);
      2'd1:    inc = DW'(2);
      default: inc = DW'(4);
    endcase
    cdec = cnt[CW-1:0] - CW'(1);
    nsar = mode[MB_SINC] ? sar + inc : sar;
    ndar = mode[MB_DINC] ? dar + inc : dar;
    ncnt = {cnt[DW-1:CW], cdec};
    stop = (cdec == '0) || mode[MB_DIS];
  end
endmodule

// File: rtl/dtx_top.sv
module dtx_top #(
  parameter int             NSRC     = 8,
  parameter int             AW       = 32,
  parameter int             DW       = 32,
  parameter int             CW       = 16,
  parameter logic [AW-1:0]  VEC_BASE = '0
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] src_req,
  input  logic [NSRC-1:0] en_set,
  input  logic            ctl_wr,
  input  logic            ctl_skip,
  output logic [NSRC-1:0] src_en,
  output logic [NSRC-1:0] src_clr,
  output logic [NSRC-1:0] cpu_irq,
  output logic            busy,
  output logic            mem_req,
  output logic            mem_we,
  output logic [AW-1:0]   mem_addr,
  output logic [DW-1:0]   mem_wdata,
  output logic [1:0]      mem_size,
  input  logic            mem_ack,
  input  logic [DW-1:0]   mem_rdata
);
  import dtx_pkg::*;
  localparam int IW   = (NSRC > 1) ? $clog2(NSRC) : 1;
  localparam int XW   = $clog2(DESC_WORDS);
  localparam int LAST = DESC_WORDS - 1;

  dtx_state_t     st;
  logic [IW-1:0]  cur;
  logic [AW-1:0]  base;
  logic [XW-1:0]  widx;
  logic [DW-1:0]  desc [DESC_WORDS];
  logic           fin_dis;
  logic [NSRC-1:0] en_q, clr_q, irq_q, dis_now;
  logic           busy_q;

  logic           any, skip_go, start, finish, wb_end;
  logic [IW-1:0]  win;
  logic [DW-1:0]  nsar, ndar, ncnt;
  logic           stop;

  dtx_arb #(.N(NSRC), .IW(IW)) u_arb (.req(src_req & en_q), .any(any), .idx(win));

  assign start  = (st == S_IDLE) && any;
  assign finish = (st == S_FIN);
  assign wb_end = (st == S_WB) && mem_ack && (widx == XW'(LAST));

  dtx_skip #(.IW(IW)) u_skip (
    .clk(clk), .rst(rst), .ctl_wr(ctl_wr), .ctl_val(ctl_skip),
    .start(start), .start_src(win), .finish(finish), .fin_src(cur),
    .skip_go(skip_go)
  );

  dtx_step #(.DW(DW), .CW(CW)) u_step (
    .mode(desc[D_MODE]), .sar(desc[D_SRC]), .dar(desc[D_DST]), .cnt(desc[D_CNT]),
    .nsar(nsar), .ndar(ndar), .ncnt(ncnt), .stop(stop)
  );

  assign dis_now = (wb_end && fin_dis) ? (NSRC'(1) << cur) : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q  <= '0;
      irq_q <= '0;
    end else begin
      en_q  <= (en_q | en_set) & ~dis_now;
      irq_q <= src_req & ~en_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= S_IDLE;
      cur       <= '0;
      base      <= '0;
      widx      <= '0;
      fin_dis   <= 1'b0;
      clr_q     <= '0;
      busy_q    <= 1'b0;
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      mem_size  <= '0;
      for (int k = 0; k < DESC_WORDS; k++) desc[k] <= '0;
    end else begin
      unique case (st)
        S_IDLE: if (any) begin
          cur     <= win;
          busy_q  <= 1'b1;
          mem_req <= 1'b1;
          mem_we  <= 1'b0;
          if (skip_go) begin
            st       <= S_RD;
            mem_addr <= desc[D_SRC][AW-1:0];
            mem_size <= desc[D_MODE][1:0];
          end else begin
            st       <= S_VEC;
            mem_addr <= VEC_BASE + (AW'(win) << 2);
          end
        end
        S_VEC: if (mem_ack) begin
          base     <= mem_rdata[AW-1:0];
          mem_addr <= mem_rdata[AW-1:0];
          widx     <= '0;
          st       <= S_DESC;
        end
        S_DESC: if (mem_ack) begin
          desc[widx] <= mem_rdata;
          if (widx == XW'(LAST)) begin
            st       <= S_RD;
            mem_addr <= desc[D_SRC][AW-1:0];
            mem_size <= desc[D_MODE][1:0];
          end else begin
            widx     <= widx + XW'(1);
            mem_addr <= mem_addr + AW'(4);
          end
        end
        S_RD: if (mem_ack) begin
          mem_we    <= 1'b1;
          mem_addr  <= desc[D_DST][AW-1:0];
          mem_wdata <= mem_rdata;
          st        <= S_WR;
        end
        S_WR: if (mem_ack) begin
          desc[D_SRC] <= nsar;
          desc[D_DST] <= ndar;
          desc[D_CNT] <= ncnt;
          fin_dis     <= stop;
          widx        <= '0;
          mem_addr    <= base;
          mem_wdata   <= desc[0];
          mem_size    <= 2'd2;
          st          <= S_WB;
        end
        S_WB: if (mem_ack) begin
          if (widx == XW'(LAST)) begin
            mem_req <= 1'b0;
            mem_we  <= 1'b0;
            if (!fin_dis) clr_q <= NSRC'(1) << cur;
            st      <= S_FIN;
          end else begin
            widx      <= widx + XW'(1);
            mem_addr  <= mem_addr + AW'(4);
            mem_wdata <= desc[widx + XW'(1)];
          end
        end
        S_FIN: begin
          clr_q  <= '0;
          busy_q <= 1'b0;
          st     <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign src_en  = en_q;
  assign src_clr = clr_q;
  assign cpu_irq = irq_q;
  assign busy    = busy_q;

  // R7: at most one clear pulse, and only for a line that stays enabled
  a_r7_clr_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0(src_clr));
  a_r7_clr_keeps_en: assert property (@(posedge clk) disable iff (rst)
    (src_clr != '0) |-> ((src_clr & src_en) == src_clr));
  // R12: request holds its address and data until acknowledged
  a_r12_req_hold: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));
  // R12: memory is touched only while busy
  a_r12_req_in_busy: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> busy);
  // R2: a rise of busy follows an enabled pending request
  a_r2_start_enabled: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> ($past(src_req & src_en) != '0));
endmodule

// File: tb/tb_dtx_top.sv
module tb_dtx_top;
  localparam int CLK_PERIOD = 10;
  localparam int N  = 8;
  localparam int NV = 5;
  localparam logic [31:0] DBASE = 32'h100;

  localparam logic [2:0]  V_SRC  [NV] = '{3'd2, 3'd5, 3'd1, 3'd7, 3'd0};
  localparam logic [31:0] V_MODE [NV] = '{32'h0E, 32'h04, 32'h09, 32'h12, 32'h0F};
  localparam logic [31:0] V_SAR  [NV] = '{32'h200, 32'h210, 32'h220, 32'h230, 32'h240};
  localparam logic [31:0] V_DAR  [NV] = '{32'h280, 32'h290, 32'h2A0, 32'h2B0, 32'h2C0};
  localparam logic [31:0] V_CNT  [NV] = '{32'd40, 32'd3, 32'd1, 32'd9, 32'd2};
  localparam logic [31:0] E_SAR  [NV] = '{32'h204, 32'h211, 32'h220, 32'h230, 32'h244};
  localparam logic [31:0] E_DAR  [NV] = '{32'h284, 32'h290, 32'h2A2, 32'h2B0, 32'h2C4};
  localparam logic [31:0] E_CNT  [NV] = '{32'd39, 32'd2, 32'd0, 32'd8, 32'd1};
  localparam logic        E_EN   [NV] = '{1'b1, 1'b1, 1'b0, 1'b0, 1'b1};

  logic clk = 0, rst = 1;
  logic [N-1:0] flag, set_req = '0, bclr = '0, en_set = '0;
  logic ctl_wr = 0, ctl_skip = 0;
  logic [N-1:0] src_en, src_clr, cpu_irq;
  logic busy, mem_req, mem_we, mem_ack;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [1:0] mem_size;
  logic hw = 0;
  logic [7:0] hidx = '0;
  logic [31:0] hdat = '0;
  logic [31:0] mem [256];
  int rd_cnt = 0, wr_cnt = 0;
  int clr_cnt [N];
  int checks = 0, fails = 0;
  int r0, w0, c0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dtx_top dut (
    .clk(clk), .rst(rst), .src_req(flag), .en_set(en_set), .ctl_wr(ctl_wr),
    .ctl_skip(ctl_skip), .src_en(src_en), .src_clr(src_clr), .cpu_irq(cpu_irq),
    .busy(busy), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_size(mem_size), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  always @(posedge clk) begin
    if (rst) flag <= '0;
    else     flag <= (flag | set_req) & ~src_clr & ~bclr;
  end

  always @(posedge clk) begin
    for (int i = 0; i < N; i++) begin
      if (rst) clr_cnt[i] <= 0;
      else if (src_clr[i]) clr_cnt[i] <= clr_cnt[i] + 1;
    end
  end

  always @(posedge clk) begin
    if (rst) mem_ack <= 1'b0;
    else begin
      mem_ack <= mem_req & ~mem_ack;
      if (hw) mem[hidx] <= hdat;
      else if (mem_req && !mem_ack) begin
        mem_rdata <= mem[mem_addr[9:2]];
        if (mem_we) begin
          mem[mem_addr[9:2]] <= mem_wdata;
          wr_cnt <= wr_cnt + 1;
        end else rd_cnt <= rd_cnt + 1;
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic hwrite(input logic [7:0] idx, input logic [31:0] d);
    hw = 1; hidx = idx; hdat = d;
    @(negedge clk);
    hw = 0;
  endtask

  task automatic setup(input int s, input logic [31:0] mode, input logic [31:0] sar,
                       input logic [31:0] dar, input logic [31:0] cnt, input logic [31:0] tagw);
    logic [31:0] d;
    d = DBASE + 32'(s) * 32'd32;
    hwrite(8'(s), d);
    hwrite(d[9:2] + 8'd0, mode);
    hwrite(d[9:2] + 8'd1, 32'h1111_0000 | tagw);
    hwrite(d[9:2] + 8'd2, sar);
    hwrite(d[9:2] + 8'd3, dar);
    hwrite(d[9:2] + 8'd4, cnt);
    hwrite(d[9:2] + 8'd5, 32'hBEEF_0000 | tagw);
    hwrite(sar[9:2], 32'hA500_0000 | tagw);
  endtask

  task automatic enable(input logic [N-1:0] m);
    en_set = m; @(negedge clk); en_set = '0;
  endtask

  task automatic ctl(input logic v);
    ctl_wr = 1; ctl_skip = v; @(negedge clk); ctl_wr = 0;
  endtask

  task automatic fire(input logic [N-1:0] m);
    set_req = m; @(negedge clk); set_req = '0;
  endtask

  task automatic wait_done();
    while (!busy) @(negedge clk);
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic one(input int s);
    r0 = rd_cnt; w0 = wr_cnt;
    fire(N'(1) << s);
    wait_done();
  endtask

  function automatic logic [7:0] dw(input int s, input int k);
    logic [31:0] d;
    d = DBASE + 32'(s) * 32'd32;
    return d[9:2] + 8'(k);
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R1 src_en", 32'(src_en), 0);
    chk("R1 busy/req/clr", {29'd0, busy, mem_req, |src_clr}, 0);
    chk("R1 cpu_irq", 32'(cpu_irq), 0);

    // table-driven single moves
    for (int r = 0; r < NV; r++) begin
      setup(int'(V_SRC[r]), V_MODE[r], V_SAR[r], V_DAR[r], V_CNT[r], 32'(r));
      enable(N'(1) << V_SRC[r]);
      chk("R2 enable set", 32'(src_en[V_SRC[r]]), 1);
      c0 = clr_cnt[V_SRC[r]];
      one(int'(V_SRC[r]));
      chk("R4 reads", 32'(rd_cnt - r0), 8);
      chk("R4 writes", 32'(wr_cnt - w0), 7);
      chk("R4 data moved", mem[V_DAR[r][9:2]], 32'hA500_0000 | 32'(r));
      chk("R6 src addr", mem[dw(int'(V_SRC[r]), 2)], E_SAR[r]);
      chk("R6 dst addr", mem[dw(int'(V_SRC[r]), 3)], E_DAR[r]);
      chk("R6 count", mem[dw(int'(V_SRC[r]), 4)], E_CNT[r]);
      chk("R5 aux words", mem[dw(int'(V_SRC[r]), 1)] ^ mem[dw(int'(V_SRC[r]), 5)],
          (32'h1111_0000 | 32'(r)) ^ (32'hBEEF_0000 | 32'(r)));
      chk("R7 enable kept", 32'(src_en[V_SRC[r]]), 32'(E_EN[r]));
      chk("R7 clear pulses", 32'(clr_cnt[V_SRC[r]] - c0), E_EN[r] ? 1 : 0);
      chk("R7 cpu request", 32'(cpu_irq[V_SRC[r]]), E_EN[r] ? 0 : 1);
      if (!E_EN[r]) begin
        bclr = N'(1) << V_SRC[r]; @(negedge clk); bclr = '0;
      end
    end

    // R2: request from a never-enabled line
    r0 = rd_cnt;
    fire(N'(1) << 3);
    repeat (3) @(negedge clk);
    chk("R2 cpu_irq routed", 32'(cpu_irq[3]), 1);
    chk("R2 no access", 32'(rd_cnt - r0), 0);
    chk("R2 no busy", 32'(busy), 0);
    bclr = N'(1) << 3; @(negedge clk); bclr = '0;
    repeat (2) @(negedge clk);
    chk("R2 cpu_irq drops", 32'(cpu_irq[3]), 0);

    // R3: two lines at once
    setup(4, 32'h0E, 32'h300, 32'h340, 32'd10, 32'h44);
    setup(6, 32'h0E, 32'h320, 32'h360, 32'd10, 32'h66);
    enable(8'h50);
    r0 = rd_cnt; c0 = clr_cnt[6];
    fire(8'h50);
    wait_done();
    chk("R3 first is line 4", 32'(clr_cnt[4]), 1);
    chk("R3 line 6 waited", 32'(clr_cnt[6] - c0), 0);
    chk("R12 one activation", 32'(rd_cnt - r0), 8);
    wait_done();
    chk("R3 line 6 served", 32'(clr_cnt[6] - c0), 1);

    // R8: skip on consecutive same line
    ctl(1'b1);
    one(2);
    chk("R8 first fetches", 32'(rd_cnt - r0), 8);
    one(2);
    chk("R8 skip reads", 32'(rd_cnt - r0), 1);
    chk("R8 skip writes", 32'(wr_cnt - w0), 7);
    chk("R8 skip count", mem[dw(2, 4)], 32'd37);
    chk("R8 skip src addr", mem[dw(2, 2)], 32'h20C);

    // R9: another line in between
    one(5);
    chk("R9 other fetches", 32'(rd_cnt - r0), 8);
    one(2);
    chk("R9 back refetches", 32'(rd_cnt - r0), 8);

    // R10: zero write forgets
    one(2);
    chk("R10 armed skip", 32'(rd_cnt - r0), 1);
    ctl(1'b0);
    ctl(1'b1);
    one(2);
    chk("R10 refetch after wipe", 32'(rd_cnt - r0), 8);

    // R11: control set during a move started with it at 0
    ctl(1'b0);
    r0 = rd_cnt;
    fire(N'(1) << 2);
    while (!busy) @(negedge clk);
    chk("R12 busy during move", 32'(busy), 1);
    ctl(1'b1);
    while (busy) @(negedge clk);
    @(negedge clk);
    one(2);
    chk("R11 not armed", 32'(rd_cnt - r0), 8);
    one(2);
    chk("R11 armed next", 32'(rd_cnt - r0), 1);
    chk("R6 count after run", mem[dw(2, 4)], 32'd31);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL R12 watchdog actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule